// File: doc/BRIEF.md
# Smart Card Oversampling Serial Receiver

This block is the receive half of a serial port that runs either as a plain asynchronous receiver or as a smart card receiver. A baud rate generator supplies a one-cycle enable pulse, the basic clock tick. The receiver counts a fixed number of these ticks per bit. In plain asynchronous mode the count is always 16. In smart card mode a two-bit select chooses 32, 64, 372 or 256 ticks per bit, so the receiver can follow the bit rates a card negotiates. In smart card mode the tick input is the only timing source. The block has no external clock input.

While idle, the receiver compares the line value at each tick with the value at the previous tick. A high-to-low change marks a start bit and clears the bit-phase counter. Every later bit is taken at the middle of its period. A character is ten bits: a low start bit, eight data bits least significant bit first, and one even-parity bit. When the parity bit has been taken, the receiver presents the data with a parity error flag and a one-cycle ready pulse. It then goes back to idle, so the next character can begin on the very next tick.

Top module: `sc_oversample_rx`

## Requirements
- R1: After synchronous reset, `rx_valid`, `parity_err` and `rx_data` are all 0.
- R2: In smart card mode (`sc_mode`=1), `ratio_sel` picks the bit period N: 2'b00=32, 2'b01=64, 2'b10=372, 2'b11=256. Take the tick that detects the start edge as tick 0. Bit k of the frame (k=0 start, 1..8 data, 9 parity) is sampled on tick k*N+N/2 and on no other tick.
- R3: In normal mode (`sc_mode`=0), N is 16 whatever the value of `ratio_sel`.
- R4: A start is recognised only on a cycle where `bclk_tick` is high, the line was high at the previous tick, and the line is low now. A low pulse that starts and ends between two ticks starts nothing.
- R5: Data bits arrive least significant bit first: frame bit 1 becomes `rx_data[0]` and frame bit 8 becomes `rx_data[7]`.
- R6: Parity is even. `parity_err` is 1 exactly when the eight data bits plus the parity bit contain an odd number of ones. It is updated on the same clock edge as the `rx_valid` pulse.
- R7: `rx_valid` is high for exactly one clock cycle. It rises on the clock edge of the parity-sampling tick. `rx_data` and `parity_err` keep their values until the next `rx_valid`.
- R8: If the line is high at the start bit's mid-point sample, the receiver returns to idle without a `rx_valid` pulse and accepts a later start edge.
- R9: `sc_mode` and `ratio_sel` take effect only on the start-edge tick. Changing them during a frame does not alter that frame.
- R10: After the parity sample the receiver is idle, and a start edge on the next tick begins a new frame (back-to-back characters).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Serial receive line, idle high |
| bclk_tick | input | 1 | Basic clock enable from the baud rate generator, one cycle wide |
| sc_mode | input | 1 | 1 = smart card mode, 0 = normal asynchronous mode |
| ratio_sel | input | 2 | Bit-period select used in smart card mode |
| rx_data | output | DATA_W | Last received data byte |
| parity_err | output | 1 | Even-parity mismatch for the last character |
| rx_valid | output | 1 | One-cycle pulse when a character is complete |

## Verification
The bench uses the default width of eight data bits and drives ticks every second clock. This brings all four smart card periods, including the non-power-of-two 372, into reach within one run. In most frames each bit holds its true value only from its mid-point onward and the opposite value before it. A receiver that samples even one tick early therefore decodes the wrong byte. Configuration changes during a frame, low pulses between ticks, false starts and back-to-back characters are each applied directly.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

    localparam int NORM_RATIO = 16;
    localparam int SC_RATIO_0 = 32;
    localparam int SC_RATIO_1 = 64;
    localparam int SC_RATIO_2 = 372;
    localparam int SC_RATIO_3 = 256;
    localparam int RATIO_MAX  = 372;
    localparam int CNT_W      = $clog2(RATIO_MAX + 1);

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUSY = 1'b1
    } rx_phase_e;

    typedef logic [CNT_W-1:0] cnt_t;

    // Ticks per bit for the selected mode.
    function automatic cnt_t bit_period(input logic sc, input logic [1:0] sel);
        cnt_t r;
        if (!sc) begin
            r = cnt_t'(NORM_RATIO);
        end else begin
            unique case (sel)
                2'b00:   r = cnt_t'(SC_RATIO_0);
                2'b01:   r = cnt_t'(SC_RATIO_1);
                2'b10:   r = cnt_t'(SC_RATIO_2);
                default: r = cnt_t'(SC_RATIO_3);
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/scr_line_edge.sv
module scr_line_edge (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line,
    output logic fall
);
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b1;
        end else if (tick) begin
            last_q <= line;
        end
    end

    assign fall = tick & last_q & ~line;
endmodule

// File: rtl/scr_phase_ctr.sv
module scr_phase_ctr
    import sc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic sync,
    input  logic run,
    input  cnt_t period,
    output cnt_t phase,
    output logic mid
);
    cnt_t phase_q;
    cnt_t phase_inc;
    cnt_t half;

    assign phase_inc = phase_q + cnt_t'(1);
    assign half      = period >> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (sync) begin
            phase_q <= '0;
        end else if (tick && run) begin
            phase_q <= (phase_q == period - cnt_t'(1)) ? '0 : phase_inc;
        end
    end

    assign phase = phase_q;
    assign mid   = tick & run & (phase_inc == half);
endmodule

// File: rtl/scr_frame_asm.sv
module scr_frame_asm
    import sc_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sample,
    input  logic              line,
    output logic              busy,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              valid
);
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    rx_phase_e         st_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] data_q;
    logic              perr_q;
    logic              valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= PH_IDLE;
            idx_q   <= '0;
            sh_q    <= '0;
            data_q  <= '0;
            perr_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start) begin
                st_q  <= PH_BUSY;
                idx_q <= '0;
            end else if (st_q == PH_BUSY && sample) begin
                if (idx_q == '0) begin
                    if (line) begin
                        st_q <= PH_IDLE;           // false start
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end else if (idx_q == LAST_IDX) begin
                    st_q    <= PH_IDLE;
                    valid_q <= 1'b1;
                    data_q  <= sh_q;
                    perr_q  <= (^sh_q) ^ line;
                end else begin
                    sh_q  <= {line, sh_q[DATA_W-1:1]};
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign busy  = (st_q == PH_BUSY);
    assign data  = data_q;
    assign perr  = perr_q;
    assign valid = valid_q;
endmodule

// File: rtl/sc_oversample_rx.sv
module sc_oversample_rx
    import sc_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic              bclk_tick,
    input  logic              sc_mode,
    input  logic [1:0]        ratio_sel,
    output logic [DATA_W-1:0] rx_data,
    output logic              parity_err,
    output logic              rx_valid
);
    logic fall_evt;
    logic start_evt;
    logic busy;
    logic mid_evt;
    cnt_t ratio_q;
    cnt_t phase_cnt;

    scr_line_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .tick (bclk_tick),
        .line (rxd),
        .fall (fall_evt)
    );

    assign start_evt = fall_evt & ~busy;

    // Period is latched only on the start-edge tick.
    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= cnt_t'(NORM_RATIO);
        end else if (start_evt) begin
            ratio_q <= bit_period(sc_mode, ratio_sel);
        end
    end

    scr_phase_ctr u_phase (
        .clk    (clk),
        .rst    (rst),
        .tick   (bclk_tick),
        .sync   (start_evt),
        .run    (busy),
        .period (ratio_q),
        .phase  (phase_cnt),
        .mid    (mid_evt)
    );

    scr_frame_asm #(.DATA_W(DATA_W)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .start  (start_evt),
        .sample (mid_evt),
        .line   (rxd),
        .busy   (busy),
        .data   (rx_data),
        .perr   (parity_err),
        .valid  (rx_valid)
    );
endmodule

// File: rtl/sc_oversample_rx_chk.sv
module sc_oversample_rx_chk #(
    parameter int CNT_W  = 9,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              busy,
    input logic              start,
    input logic [CNT_W-1:0]  phase,
    input logic [CNT_W-1:0]  ratio_q,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data
);
    assert_phase_bound_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (phase < ratio_q));

    assert_sync_clears_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (phase == '0));

    assert_start_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(tick));

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_valid_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(tick));

    assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> rx_valid);

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(ratio_q));
endmodule

bind sc_oversample_rx sc_oversample_rx_chk #(
    .CNT_W  (sc_rx_pkg::CNT_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (bclk_tick),
    .busy     (busy),
    .start    (start_evt),
    .phase    (phase_cnt),
    .ratio_q  (ratio_q),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
);

// File: tb/sc_oversample_rx_tb.sv
`timescale 1ns/1ps
module sc_oversample_rx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       bclk_tick = 1'b0;
    logic       sc_mode = 1'b0;
    logic [1:0] ratio_sel = 2'b00;
    logic [7:0] rx_data;
    logic       parity_err;
    logic       rx_valid;

    int n_checks = 0;
    int n_errors = 0;
    int n_valid  = 0;
    int n_sent   = 0;
    bit done     = 1'b0;
    logic prev_valid = 1'b0;

    typedef struct packed {
        logic [7:0] d;
        logic       pe;
        logic [7:0] tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    sc_oversample_rx u_dut (
        .clk        (clk),
        .rst        (rst),
        .rxd        (rxd),
        .bclk_tick  (bclk_tick),
        .sc_mode    (sc_mode),
        .ratio_sel  (ratio_sel),
        .rx_data    (rx_data),
        .parity_err (parity_err),
        .rx_valid   (rx_valid)
    );

    function automatic int period_of(input logic sc, input logic [1:0] sel);
        if (!sc) return 16;
        case (sel)
            2'b00:   return 32;
            2'b01:   return 64;
            2'b10:   return 372;
            default: return 256;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare on every ready pulse.
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                n_valid++;
                check(!prev_valid, "R7 pulse width", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected ready pulse", int'(rx_data), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rx_data == e.d, $sformatf("R5 R2 data (case %0d)", e.tag),
                          int'(rx_data), int'(e.d));
                    check(parity_err == e.pe, $sformatf("R6 parity flag (case %0d)", e.tag),
                          int'(parity_err), int'(e.pe));
                end
            end
            prev_valid <= rx_valid;
        end
    end

    task automatic do_tick(input logic v);
        @(negedge clk);
        rxd       = v;
        bclk_tick = 1'b1;
        @(negedge clk);
        bclk_tick = 1'b0;
    endtask

    // Driver: pushes the expected item then drives one frame tick by tick.
    // narrow: each bit is inverted before its mid-point tick.
    // disturb: mode and select are changed right after the start tick.
    // tail_high: line returned high after the frame.
    task automatic send_frame(input logic [7:0] d, input logic flip_par,
                              input logic mode, input logic [1:0] sel,
                              input bit narrow, input bit disturb, input bit tail_high,
                              input logic [7:0] tag);
        int n;
        logic [9:0] bits;
        exp_t e;
        n = period_of(mode, sel);
        bits = {(^d) ^ flip_par, d, 1'b0};
        e.d = d; e.pe = flip_par; e.tag = tag;
        exp_q.push_back(e);
        n_sent++;
        sc_mode   = mode;
        ratio_sel = sel;
        for (int t = 0; t < 10 * n; t++) begin
            int k;
            int ph;
            logic v;
            k  = t / n;
            ph = t % n;
            v  = bits[k];
            if (narrow && t != 0 && ph < n / 2) v = ~v;
            do_tick(v);
            if (disturb && t == 0) begin
                sc_mode   = ~mode;
                ratio_sel = ~sel;
            end
        end
        if (tail_high) rxd = 1'b1;
    endtask

    task automatic idle_ticks(input int cnt);
        for (int i = 0; i < cnt; i++) do_tick(1'b1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(rx_valid == 1'b0, "R1 rx_valid after reset", int'(rx_valid), 0);
        check(parity_err == 1'b0, "R1 parity_err after reset", int'(parity_err), 0);
        check(rx_data == 8'h00, "R1 rx_data after reset", int'(rx_data), 0);
        idle_ticks(3);

        // R2 each smart card period, mid-point sampling exact
        send_frame(8'hA5, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 8'd1);
        idle_ticks(3);
        send_frame(8'h3C, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 8'd2);
        idle_ticks(3);
        send_frame(8'h81, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 8'd3);
        idle_ticks(3);
        send_frame(8'h5E, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 1'b1, 8'd4);
        idle_ticks(3);

        // R3 normal mode ignores ratio_sel
        send_frame(8'h01, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 1'b1, 8'd5);
        idle_ticks(3);
        send_frame(8'hFE, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 1'b1, 8'd6);
        idle_ticks(3);

        // R6 parity error, odd and even data weight
        send_frame(8'h07, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 8'd7);
        idle_ticks(3);
        send_frame(8'h66, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 8'd8);
        idle_ticks(5);
        // R7 outputs held while idle
        check(rx_data == 8'h66, "R7 rx_data held", int'(rx_data), 8'h66);
        check(parity_err == 1'b1, "R7 parity_err held", int'(parity_err), 1);

        // R8 false start: low only briefly, high at the mid-point
        sc_mode = 1'b1; ratio_sel = 2'b00;
        do_tick(1'b0);
        for (int i = 1; i < 40; i++) do_tick(i < 4 ? 1'b0 : 1'b1);
        idle_ticks(10);
        check(n_valid == n_sent, "R8 no pulse after false start", n_valid, n_sent);
        send_frame(8'hC3, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 8'd9);
        idle_ticks(3);

        // R4 low pulse between ticks starts nothing
        @(negedge clk); rxd = 1'b0;
        @(negedge clk); rxd = 1'b1;
        idle_ticks(4);
        send_frame(8'h2D, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 8'd10);
        idle_ticks(3);

        // R9 configuration changes during a frame are ignored
        send_frame(8'h96, 1'b0, 1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 8'd11);
        idle_ticks(3);
        send_frame(8'h4B, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 1'b1, 8'd12);
        idle_ticks(3);

        // R10 back-to-back frames (parity bit 1 so the next start is an edge)
        send_frame(8'h01, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 8'd13);
        send_frame(8'h70, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 8'd14);
        send_frame(8'hEA, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 8'd15);
        idle_ticks(5);

        check(exp_q.size() == 0, "R10 all characters received", exp_q.size(), 0);
        check(n_valid == n_sent, "R8 pulse count", n_valid, n_sent);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule